// File: doc/BRIEF.md
# Serial Slave Configuration Master

This block loads a configuration image into a target device through that device's slave serial configuration port. A single `start` pulse with a byte count launches one load. The sequence has four steps. First the program-enable line is held low for a set number of cycles and then released. The block then polls the target's init-ready line. Once that line is high, the block shifts the requested number of bytes out, most significant bit first, with one clock pulse per bit. Finally it keeps issuing single clock pulses until the target raises its done line. Both waits are bounded, and if either bound runs out the load ends in a failure state.

Bytes come from a simple stream source. The block raises `src_take_o` in the cycle it consumes `src_data_i`, and the source can end the load early with `src_err_i`. The configuration clock is a divided version of the system clock, with a high time and a low time of `CCLK_HALF` system cycles each. The result stays on `success_o` or `error_o` until the next start.

The controller has nine named states:
- `ST_IDLE`: waits for a start.
- `ST_PROG`: program pulse.
- `ST_INIT`: init poll.
- `ST_FETCH`: takes a byte from the stream.
- `ST_SHIFT`: byte being shifted out.
- `ST_KICK`: checks DONE and decides whether to issue another post-load pulse.
- `ST_PULSE`: post-load pulse running.
- `ST_PASS`: load succeeded.
- `ST_FAIL`: load failed.

The transitions are:
- IDLE/PASS/FAIL→PROG on start.
- PROG→INIT after the pulse width.
- INIT→FETCH when init-ready is high and there are bytes to send.
- INIT→KICK when init-ready is high and the length is zero.
- INIT→FAIL when the poll limit runs out.
- FETCH→SHIFT on a valid byte.
- FETCH→FAIL on a stream error.
- SHIFT→FETCH after a byte when bytes remain.
- SHIFT→KICK after the last byte.
- KICK→PASS when DONE is high.
- KICK→FAIL when the pulse limit is reached.
- KICK→PULSE otherwise.
- PULSE→KICK when the pulse ends.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset and whenever not loading, `nprog_o` is 1, `cclk_o` and `din_o` are 0, and `busy_o`, `success_o` and `error_o` are 0 (the result flags stay 0 until the first load ends).
- R2: After a start, `nprog_o` is low for exactly `PROG_LOW_CYC` system cycles and is then high for the rest of the load.
- R3: After the program pulse, init-ready is polled once per cycle. If it is not high within `INIT_POLLS` polls, the load fails with no `cclk_o` pulse and no byte taken.
- R4: Each bit is one `cclk_o` pulse, high for `CCLK_HALF` cycles and low for `CCLK_HALF` cycles. `din_o` is set at least one cycle before the rising edge and does not change at it.
- R5: Each byte is sent as bit 7 first down to bit 0. Exactly `length_i` bytes are taken (`src_take_o` high only while `src_valid_i` is high and `src_err_i` is low) and sent. A length of 0 sends no data.
- R6: If `src_err_i` is high when a byte is due, the load fails at once. No further bytes are taken and no further pulses are issued.
- R7: After the data, single `cclk_o` pulses with `din_o` at 0 are issued. DONE is sampled before each pulse, and the load succeeds as soon as DONE is seen high.
- R8: If DONE has not been seen after `DONE_PULSES` post-load pulses, the load fails. DONE seen at the check where the limit is reached still counts as success.
- R9: `busy_o` is high from the cycle after start until the result. `success_o` and `error_o` are never both high and hold until the next start.
- R10: A start pulse during a load is ignored; the running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a load (accepted when not busy) |
| length_i | input | LEN_W | Number of bytes to send, latched at start |
| src_data_i | input | 8 | Byte offered by the stream source |
| src_valid_i | input | 1 | Source byte valid |
| src_err_i | input | 1 | Source failure; aborts the load |
| src_take_o | output | 1 | Byte consumed this cycle |
| ninit_i | input | 1 | Target init-ready (high = ready) |
| done_i | input | 1 | Target configuration done |
| nprog_o | output | 1 | Program-enable, active low |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration data |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | Last load finished with DONE seen |
| error_o | output | 1 | Last load timed out or the stream failed |

## Verification
The two functions that can meet in the same cycle are the DONE check and the post-load pulse limit. Both are decided in the KICK state, where DONE is examined before the limit. The bench provokes this by sweeping the number of pulses the target model needs before raising DONE, from zero up to exactly `DONE_PULSES`. At the top value, DONE arrives at the check where the limit is also reached, and the bench expects success with exactly `DONE_PULSES` extra pulses counted on `cclk_o`. One pulse further, in the never-done run, the bench expects failure after the same pulse count.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT,
        ST_FETCH,
        ST_SHIFT,
        ST_KICK,
        ST_PULSE,
        ST_PASS,
        ST_FAIL
    } ld_state_e;

    localparam int unsigned BYTE_BITS = 8;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int unsigned CCLK_HALF = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [3:0] nbits_i,
    input  logic [7:0] byte_i,
    output logic       cclk_o,
    output logic       din_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int unsigned CW = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;
    localparam logic [CW-1:0] PH_LAST = CW'(CCLK_HALF - 1);

    logic [7:0]    sh_q;
    logic [3:0]    left_q;
    logic [CW-1:0] ph_q;
    logic          hi_q;
    logic          act_q;
    logic          din_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            ph_q   <= '0;
            hi_q   <= 1'b0;
            act_q  <= 1'b0;
            din_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i && !act_q) begin
                sh_q   <= byte_i;
                left_q <= nbits_i;
                din_q  <= byte_i[7];
                hi_q   <= 1'b0;
                ph_q   <= '0;
                act_q  <= 1'b1;
            end else if (act_q) begin
                if (ph_q == PH_LAST) begin
                    ph_q <= '0;
                    if (!hi_q) begin
                        hi_q <= 1'b1;
                    end else begin
                        hi_q <= 1'b0;
                        if (left_q == 4'd1) begin
                            act_q  <= 1'b0;
                            done_q <= 1'b1;
                            din_q  <= 1'b0;
                        end else begin
                            sh_q   <= {sh_q[6:0], 1'b0};
                            din_q  <= sh_q[6];
                            left_q <= left_q - 4'd1;
                        end
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign cclk_o = hi_q;
    assign din_o  = din_q;
    assign busy_o = act_q;
    assign done_o = done_q;

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned CCLK_HALF    = 3,
    parameter int unsigned PROG_LOW_CYC = 1200,
    parameter int unsigned INIT_POLLS   = 100000,
    parameter int unsigned DONE_PULSES  = 100000,
    parameter int unsigned LEN_W        = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] length_i,
    input  logic [7:0]       src_data_i,
    input  logic             src_valid_i,
    input  logic             src_err_i,
    output logic             src_take_o,
    input  logic             ninit_i,
    input  logic             done_i,
    output logic             nprog_o,
    output logic             cclk_o,
    output logic             din_o,
    output logic             busy_o,
    output logic             success_o,
    output logic             error_o
);

    localparam int unsigned TMAX = max3(PROG_LOW_CYC, INIT_POLLS, DONE_PULSES);
    localparam int unsigned TW   = $clog2(TMAX + 1) + 1;
    localparam logic [TW-1:0] PROG_END  = TW'(PROG_LOW_CYC - 1);
    localparam logic [TW-1:0] INIT_END  = TW'(INIT_POLLS - 1);
    localparam logic [TW-1:0] PULSE_CAP = TW'(DONE_PULSES);

    ld_state_e        state_q, state_d;
    logic [LEN_W-1:0] remain_q;
    logic             tmr_clr, tmr_inc;
    logic [TW-1:0]    tmr_cnt;
    logic             sh_load, sh_busy, sh_done;
    logic [3:0]       sh_nbits;
    logic [7:0]       sh_byte;
    logic             dec_len;
    logic             accept;

    cfg_wait_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .cnt_o (tmr_cnt)
    );

    cfg_bit_shifter #(.CCLK_HALF(CCLK_HALF)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .nbits_i (sh_nbits),
        .byte_i  (sh_byte),
        .cclk_o  (cclk_o),
        .din_o   (din_o),
        .busy_o  (sh_busy),
        .done_o  (sh_done)
    );

    // next-state and datapath control
    always_comb begin
        state_d    = state_q;
        tmr_clr    = 1'b0;
        tmr_inc    = 1'b0;
        sh_load    = 1'b0;
        sh_nbits   = 4'(BYTE_BITS);
        sh_byte    = src_data_i;
        src_take_o = 1'b0;
        dec_len    = 1'b0;
        accept     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_i) begin
                    accept  = 1'b1;
                    tmr_clr = 1'b1;
                    state_d = ST_PROG;
                end
            end
            ST_PROG: begin
                tmr_inc = 1'b1;
                if (tmr_cnt == PROG_END) begin
                    tmr_clr = 1'b1;
                    state_d = ST_INIT;
                end
            end
            ST_INIT: begin
                tmr_inc = 1'b1;
                if (ninit_i) begin
                    tmr_clr = 1'b1;
                    state_d = (remain_q == '0) ? ST_KICK : ST_FETCH;
                end else if (tmr_cnt == INIT_END) begin
                    state_d = ST_FAIL;
                end
            end
            ST_FETCH: begin
                if (src_err_i) begin
                    state_d = ST_FAIL;
                end else if (src_valid_i && !sh_busy) begin
                    src_take_o = 1'b1;
                    sh_load    = 1'b1;
                    dec_len    = 1'b1;
                    state_d    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    state_d = (remain_q == '0) ? ST_KICK : ST_FETCH;
                end
            end
            ST_KICK: begin
                if (done_i) begin
                    state_d = ST_PASS;
                end else if (tmr_cnt == PULSE_CAP) begin
                    state_d = ST_FAIL;
                end else begin
                    sh_load  = 1'b1;
                    sh_nbits = 4'd1;
                    sh_byte  = 8'h00;
                    tmr_inc  = 1'b1;
                    state_d  = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (sh_done) begin
                    state_d = ST_KICK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                remain_q <= length_i;
            end else if (dec_len) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        nprog_o   = 1'b1;
        busy_o    = 1'b1;
        success_o = 1'b0;
        error_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_PROG: nprog_o = 1'b0;
            ST_PASS: begin
                busy_o    = 1'b0;
                success_o = 1'b1;
            end
            ST_FAIL: begin
                busy_o  = 1'b0;
                error_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic src_valid_i,
    input logic src_err_i,
    input logic src_take_o,
    input logic done_i,
    input logic nprog_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic success_o,
    input logic error_o
);

    // R4
    din_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && error_o));

    // R9
    busy_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!success_o && !error_o));

    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (nprog_o && !cclk_o && !din_o));

    // R2
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nprog_o |-> !cclk_o);

    // R5
    take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_take_o |-> (busy_o && src_valid_i && !src_err_i));

    // R7
    pass_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success_o) |-> $past(done_i));

endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_valid_i (src_valid_i),
    .src_err_i   (src_err_i),
    .src_take_o  (src_take_o),
    .done_i      (done_i),
    .nprog_o     (nprog_o),
    .cclk_o      (cclk_o),
    .din_o       (din_o),
    .busy_o      (busy_o),
    .success_o   (success_o),
    .error_o     (error_o)
);

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;

    localparam int HALF  = 2;
    localparam int PLOW  = 5;
    localparam int IPOLL = 40;
    localparam int DPUL  = 6;
    localparam int LW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] length = '0;
    logic [7:0] src_data;
    logic src_valid, src_err, src_take;
    logic ninit, done;
    logic nprog, cclk, din, busy, success, error;

    always #5 clk = ~clk;

    serial_cfg_loader #(
        .CCLK_HALF(HALF), .PROG_LOW_CYC(PLOW), .INIT_POLLS(IPOLL),
        .DONE_PULSES(DPUL), .LEN_W(LW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .length_i(length),
        .src_data_i(src_data), .src_valid_i(src_valid), .src_err_i(src_err),
        .src_take_o(src_take), .ninit_i(ninit), .done_i(done),
        .nprog_o(nprog), .cclk_o(cclk), .din_o(din), .busy_o(busy),
        .success_o(success), .error_o(error)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    // target and source models; the task only writes the cfg_/base_ variables
    int cfg_len = 0, cfg_extra = 0, cfg_err_at = -1, cfg_idelay = 0, seed = 0;
    bit cfg_never_init = 0, cfg_never_done = 0;
    int takes = 0, rises = 0, plow = 0, hicyc = 0, flushbad = 0, icnt = 0;
    int base_takes = 0, base_rises = 0, base_plow = 0, base_hi = 0, base_fb = 0;
    logic [7:0] cap [0:15];

    function automatic logic [7:0] pat(input int k, input int s);
        return 8'((k * 37 + s * 11 + 5) & 255);
    endfunction

    assign src_valid = 1'b1;
    assign src_data  = pat(takes - base_takes, seed);
    assign src_err   = (cfg_err_at >= 0) && ((takes - base_takes) == cfg_err_at);
    assign ninit     = !cfg_never_init && nprog && (icnt >= cfg_idelay);
    assign done      = !cfg_never_done && ((rises - base_rises) >= 8 * cfg_len + cfg_extra);

    always @(posedge clk) begin
        if (src_take) takes <= takes + 1;
        if (!nprog) icnt <= 0;
        else if (icnt < 100000) icnt <= icnt + 1;
    end

    always @(negedge clk) begin
        if (!nprog) plow <= plow + 1;
        if (cclk) hicyc <= hicyc + 1;
    end

    always @(posedge cclk) begin
        int rel;
        rel = rises - base_rises;
        if (rel < 8 * cfg_len && rel < 128)
            cap[rel / 8] = {cap[rel / 8][6:0], din};
        else if (din)
            flushbad = flushbad + 1;
        rises = rises + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int len, input int extra, input bit never_done,
                       input int idelay, input bit never_init, input int err_at,
                       input int restart_at);
        bit exp_ok;
        int exp_rises, exp_takes, cyc;
        bit ended;
        @(negedge clk);
        seed++;
        cfg_len = len; cfg_extra = extra; cfg_never_done = never_done;
        cfg_idelay = idelay; cfg_never_init = never_init; cfg_err_at = err_at;
        base_takes = takes; base_rises = rises; base_plow = plow;
        base_hi = hicyc; base_fb = flushbad;
        length = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !success && !error, "R9 busy after start", int'(busy), 1);
        cyc = 0; ended = 0;
        while (!ended && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == restart_at);
            if (success || error) ended = 1;
        end
        start = 1'b0;
        chk(ended, "R9 load finishes", cyc, 0);
        if (never_init) begin
            exp_ok = 0; exp_rises = 0; exp_takes = 0;
        end else if (err_at >= 0 && err_at < len) begin
            exp_ok = 0; exp_rises = 8 * err_at; exp_takes = err_at;
        end else if (never_done) begin
            exp_ok = 0; exp_rises = 8 * len + DPUL; exp_takes = len;
        end else begin
            exp_ok = 1; exp_rises = 8 * len + extra; exp_takes = len;
        end
        repeat (3) @(negedge clk);
        chk(success == exp_ok && error == !exp_ok, exp_ok ? "R7 success" : "R3 R6 R8 error",
            int'(success), int'(exp_ok));
        chk(!busy && nprog && !cclk && !din, "R1 idle levels after load", int'(busy), 0);
        chk(plow - base_plow == PLOW, "R2 program pulse width", plow - base_plow, PLOW);
        chk(takes - base_takes == exp_takes, "R5 R6 bytes taken", takes - base_takes, exp_takes);
        chk(rises - base_rises == exp_rises, "R7 R8 cclk pulses", rises - base_rises, exp_rises);
        chk(hicyc - base_hi == HALF * exp_rises, "R4 cclk high time", hicyc - base_hi,
            HALF * exp_rises);
        chk(flushbad == base_fb, "R7 din low in post-load pulses", flushbad - base_fb, 0);
        for (int k = 0; k < exp_takes; k++)
            chk(cap[k] == pat(k, seed), "R5 byte MSB first", int'(cap[k]), int'(pat(k, seed)));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(nprog == 1'b1, "R1 nprog", int'(nprog), 1);
        chk(cclk == 1'b0 && din == 1'b0, "R1 cclk din", int'(cclk), 0);
        chk(!busy && !success && !error, "R1 flags", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(nprog && !cclk && !din && !busy && !success && !error, "R1 after reset",
            int'(busy), 0);
        // R5 R7 R8 sweep of length and DONE latency, incl. DONE at the limit check
        for (int l = 0; l <= 4; l++)
            for (int e = 0; e <= DPUL; e++)
                run(l, e, 0, 0, 0, -1, 0);
        // R3 init never rises
        run(2, 0, 0, 0, 1, -1, 0);
        // R3 late init within the poll bound
        run(2, 1, 0, 30, 0, -1, 0);
        // R8 DONE never rises
        run(1, 0, 1, 0, 0, -1, 0);
        // R6 stream failure mid-load and on the first byte
        run(4, 0, 0, 0, 0, 2, 0);
        run(3, 0, 0, 0, 0, 0, 0);
        // R10 start during a load is ignored
        run(3, 1, 0, 0, 0, -1, 20);
        run(2, 2, 0, 0, 0, -1, 40);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule